// File: doc/BRIEF.md
# Sign/Zero Extension Micro-op Unit

This is a purely combinational execution unit for a 64-bit register micro-op datapath. It widens part of a source register in one of two ways. Zero extension keeps the low bits and clears the rest. Sign extension copies one chosen bit into every bit above it. The position operand is the index of the highest bit kept, not a bit count. A byte source therefore uses 7, a halfword 15 and a word 31.

The extended value is then written into the destination register according to the operation data size of 1, 2, 4 or 8 bytes. Narrow sizes preserve the upper destination bits. A 4-byte write clears the upper half. An 8-byte write replaces the whole register.

A sign-extend op can also update the carry and zero flags, including their extended copies, from the extracted sign bit. Which of these flags change is chosen by a per-op select mask. The unit has no state, so the caller presents an op and takes both results in the same cycle.

Top module: `sxt_unit`

## Requirements
- R1: Zero extension (`op_sext`=0) outputs source bits 0 through the position and zeros above, before the size merge.
- R2: For zero extension only the low 6 bits of `pos` are used, so position 71 acts as position 7.
- R3: Sign extension (`op_sext`=1) takes the sign from source bit `pos & (size_bits-1)`, where `size_bits` is 8, 16, 32 or 64. When that bit is 1, every bit above it is set and the bits below pass through unchanged.
- R4: When the sign-extend sign bit is 0, every bit above the effective position is cleared and the bits below pass through unchanged.
- R5: Size codes 0 (1 byte) and 1 (2 bytes) write only the low 8 or 16 bits of `dst_new`. The remaining bits are copied from `dst_old`.
- R6: Size code 2 (4 bytes) writes the low 32 bits and forces `dst_new[63:32]` to zero.
- R7: Size code 3 (8 bytes) writes all 64 bits, and `dst_old` has no effect.
- R8: On a sign-extend op with `flag_en`=1 and sign bit 1, every flag that is both set in `flag_sel` and one of CF (bit 0), ZF (bit 6), ECF (bit 16) or EZF (bit 17) is set in `flags_out`.
- R9: On a sign-extend op with `flag_en`=1 and sign bit 0, those selected flags are cleared. All other bits of `flags_out` equal `flags_in`.
- R10: When `flag_en`=0, or the op is a zero extension, `flags_out` equals `flags_in`.
- R11: Both outputs depend only on the present inputs and are valid in the same cycle, with no clock or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sext | input | 1 | 1 = sign extension, 0 = zero extension |
| flag_en | input | 1 | Enables the flag update of a sign-extend op |
| size_code | input | 2 | Data size: 0=1B, 1=2B, 2=4B, 3=8B |
| pos | input | 8 | Index of the highest kept source bit |
| src_val | input | 64 | Source operand |
| dst_old | input | 64 | Previous destination register value |
| flag_sel | input | 32 | Per-op flag select mask |
| flags_in | input | 32 | Current flag word |
| dst_new | output | 64 | Merged destination value |
| flags_out | output | 32 | Updated flag word |

## Verification
Neither output passes through a register, so both `dst_new` and `flags_out` are due zero cycles after an input change. The bench applies each vector on a falling clock edge and reads the outputs a quarter period later, in the same cycle and well before the next rising edge. No check waits on a clock edge to see a result, and none samples at an edge where drive and sample could race.

// File: rtl/sxt_pkg.sv
package sxt_pkg;

  localparam int FLAG_W = 32;

  // Condition-code flag positions in the flag word
  localparam int CF_BIT  = 0;
  localparam int ZF_BIT  = 6;
  localparam int ECF_BIT = 16;
  localparam int EZF_BIT = 17;

  localparam logic [FLAG_W-1:0] CC_MASK =
      (FLAG_W'(1) << CF_BIT)  | (FLAG_W'(1) << ZF_BIT) |
      (FLAG_W'(1) << ECF_BIT) | (FLAG_W'(1) << EZF_BIT);

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } size_e;

endpackage

// File: rtl/sxt_ext_core.sv
module sxt_ext_core #(
  parameter int DATA_W = 64,
  parameter int POS_W  = 8
) (
  input  logic              is_sext,
  input  logic [1:0]        size_code,
  input  logic [POS_W-1:0]  pos,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] ext_val,
  output logic              sign_bit
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W:0]      width_bits;
  logic [IDX_W-1:0]    width_m1;
  logic [IDX_W-1:0]    sx_pos;
  logic [IDX_W-1:0]    zx_pos;
  logic [IDX_W-1:0]    eff_pos;
  logic [DATA_W-1:0]   keep;
  wire                 unused_pos_hi = ^pos[POS_W-1:IDX_W];

  always_comb begin
    width_bits = (IDX_W+1)'(8) << size_code;
    width_m1   = IDX_W'(width_bits - 1'b1);
    sx_pos     = pos[IDX_W-1:0] & width_m1;
    zx_pos     = pos[IDX_W-1:0];
    eff_pos    = is_sext ? sx_pos : zx_pos;
    sign_bit   = src[sx_pos];
  end

  // Keep-mask: ones at every index up to and including the effective position
  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    assign keep[i] = (i <= int'(eff_pos));
  end

  always_comb begin
    if (is_sext && sign_bit) ext_val = src | ~keep;
    else                     ext_val = src & keep;
  end

endmodule

// File: rtl/sxt_merge.sv
module sxt_merge #(
  parameter int DATA_W   = 64,
  parameter int ZX_BYTES = 4
) (
  input  logic [1:0]        size_code,
  input  logic [DATA_W-1:0] ext_val,
  input  logic [DATA_W-1:0] dst_old,
  output logic [DATA_W-1:0] dst_new
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W:0]    width_bits;
  logic [3:0]        nbytes;
  logic              clear_upper;
  logic [DATA_W-1:0] lane;

  always_comb begin
    width_bits  = (IDX_W+1)'(8) << size_code;
    nbytes      = 4'd1 << size_code;
    clear_upper = (int'(nbytes) >= ZX_BYTES);
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign lane[i] = (i < int'(width_bits));
  end

  always_comb begin
    if (clear_upper) dst_new = ext_val & lane;
    else             dst_new = (ext_val & lane) | (dst_old & ~lane);
  end

endmodule

// File: rtl/sxt_flag_upd.sv
module sxt_flag_upd
  import sxt_pkg::*;
(
  input  logic              upd_en,
  input  logic              sign_bit,
  input  logic [FLAG_W-1:0] flag_sel,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out
);
  logic [FLAG_W-1:0] hit;

  always_comb begin
    hit = flag_sel & CC_MASK;
    if (!upd_en)       flags_out = flags_in;
    else if (sign_bit) flags_out = flags_in | hit;
    else               flags_out = flags_in & ~hit;
  end

endmodule

// File: rtl/sxt_unit.sv
module sxt_unit
  import sxt_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int POS_W    = 8,
  parameter int ZX_BYTES = 4
) (
  input  logic              op_sext,
  input  logic              flag_en,
  input  logic [1:0]        size_code,
  input  logic [POS_W-1:0]  pos,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [FLAG_W-1:0] flag_sel,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] dst_new,
  output logic [FLAG_W-1:0] flags_out
);
  logic [DATA_W-1:0] ext_val;
  logic              sign_bit;

  sxt_ext_core #(.DATA_W(DATA_W), .POS_W(POS_W)) u_core (
    .is_sext  (op_sext),
    .size_code(size_code),
    .pos      (pos),
    .src      (src_val),
    .ext_val  (ext_val),
    .sign_bit (sign_bit)
  );

  sxt_merge #(.DATA_W(DATA_W), .ZX_BYTES(ZX_BYTES)) u_merge (
    .size_code(size_code),
    .ext_val  (ext_val),
    .dst_old  (dst_old),
    .dst_new  (dst_new)
  );

  sxt_flag_upd u_flags (
    .upd_en   (op_sext & flag_en),
    .sign_bit (sign_bit),
    .flag_sel (flag_sel),
    .flags_in (flags_in),
    .flags_out(flags_out)
  );

endmodule

// File: rtl/sxt_unit_chk.sv
module sxt_unit_chk
  import sxt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int POS_W  = 8
) (
  input logic              op_sext,
  input logic              flag_en,
  input logic [1:0]        size_code,
  input logic [POS_W-1:0]  pos,
  input logic [DATA_W-1:0] src_val,
  input logic [DATA_W-1:0] dst_old,
  input logic [FLAG_W-1:0] flags_in,
  input logic [DATA_W-1:0] dst_new,
  input logic [FLAG_W-1:0] flags_out
);
  localparam int IDX_W = $clog2(DATA_W);

  always_comb begin
    AST_FLAGS_PASS: assert (op_sext && flag_en || flags_out == flags_in); // R10
    AST_NONCC_KEPT: assert (((flags_out ^ flags_in) & ~CC_MASK) == '0); // R9
    AST_ZX_UPPER_CLEAR: assert (op_sext || size_code != SZ_B8 ||
                                ((dst_new >> pos[IDX_W-1:0]) >> 1) == '0); // R1
    AST_SX_TOP_SIGN: assert (!op_sext || size_code != SZ_B8 ||
                             dst_new[DATA_W-1] == src_val[pos[IDX_W-1:0]]); // R3
    AST_WORD_UPPER_ZERO: assert (size_code != SZ_B4 ||
                                 dst_new[DATA_W-1:DATA_W/2] == '0); // R6
    AST_BYTE_UPPER_KEPT: assert (size_code != SZ_B1 ||
                                 dst_new[DATA_W-1:8] == dst_old[DATA_W-1:8]); // R5
  end

endmodule

bind sxt_unit sxt_unit_chk #(.DATA_W(DATA_W), .POS_W(POS_W)) u_chk (.*);

// File: tb/tb_sxt_unit.sv
`timescale 1ns/1ps
module tb_sxt_unit;
  localparam int HALF = 10;  // 50 MHz

  typedef struct packed {
    logic        op;
    logic        fen;
    logic [1:0]  sz;
    logic [7:0]  pos;
    logic [63:0] src;
    logic [63:0] dst;
    logic [31:0] fsel;
    logic [31:0] fin;
    logic [63:0] xd;
    logic [31:0] xf;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    // R3 R8: byte sign 1, flags set
    '{1'b1,1'b1,2'd3,8'd7, 64'h80, 64'hFFFFFFFFFFFFFFFF, 32'h00030041, 32'h0,
      64'hFFFFFFFFFFFFFF80, 32'h00030041, 8'd3},
    // R4 R9: sign 0, only CC flags cleared
    '{1'b1,1'b1,2'd3,8'd7, 64'h123456789ABCDE7F, 64'h0, 32'hFFFFFFFF, 32'hFFFFFFFF,
      64'h7F, 32'hFFFCFFBE, 8'd9},
    // R6 R10: 4-byte merge, flags untouched
    '{1'b1,1'b0,2'd2,8'd15, 64'hAAAAAAAA00008001, 64'h0123456789ABCDEF, 32'hFFFFFFFF, 32'h12345678,
      64'h00000000FFFF8001, 32'h12345678, 8'd6},
    // R3: position 39 wraps to 7 at 4 bytes
    '{1'b1,1'b0,2'd2,8'd39, 64'hF0, 64'h5555555555555555, 32'h0, 32'h0,
      64'h00000000FFFFFFF0, 32'h0, 8'd3},
    // R5: 1-byte sign extend keeps upper dest
    '{1'b1,1'b1,2'd0,8'd3, 64'h08, 64'h1122334455667788, 32'h1, 32'h0,
      64'h11223344556677F8, 32'h1, 8'd5},
    // R4 R9: 2-byte, position 31 wraps to 15, ZF/EZF cleared
    '{1'b1,1'b1,2'd1,8'd31, 64'h7FFF, 64'hAAAAAAAAAAAAAAAA, 32'h00020040, 32'h41,
      64'hAAAAAAAAAAAA7FFF, 32'h1, 8'd4},
    // R10: zero extend never touches flags
    '{1'b0,1'b1,2'd3,8'd7, 64'hFFFFFFFFFFFFFFFF, 64'h0, 32'hFFFFFFFF, 32'h5,
      64'hFF, 32'h5, 8'd10},
    // R1 R7
    '{1'b0,1'b0,2'd3,8'd15, 64'h123456789ABCDEF0, 64'hFFFFFFFFFFFFFFFF, 32'h0, 32'h0,
      64'hDEF0, 32'h0, 8'd1},
    // R1: odd position
    '{1'b0,1'b0,2'd3,8'd5, 64'hFF, 64'h0, 32'h0, 32'h0,
      64'h3F, 32'h0, 8'd1},
    // R2: position 71 masked to 7
    '{1'b0,1'b0,2'd3,8'd71, 64'hFFFFFFFFFFFFFFFF, 64'h0, 32'h0, 32'h0,
      64'hFF, 32'h0, 8'd2},
    // R5: 1-byte zero extend
    '{1'b0,1'b0,2'd0,8'd3, 64'hFF, 64'h1122334455667788, 32'h0, 32'h0,
      64'h112233445566770F, 32'h0, 8'd5},
    // R6: 4-byte zero extend
    '{1'b0,1'b0,2'd2,8'd63, 64'h123456789ABCDEF0, 64'hFFFFFFFFFFFFFFFF, 32'h0, 32'h0,
      64'h000000009ABCDEF0, 32'h0, 8'd6},
    // R8: top bit sign, ECF only
    '{1'b1,1'b1,2'd3,8'd63, 64'h8000000000000000, 64'h0, 32'h00010000, 32'h0,
      64'h8000000000000000, 32'h00010000, 8'd8},
    // R8: position 0, flags already set
    '{1'b1,1'b1,2'd3,8'd0, 64'h1, 64'h0, 32'h00030041, 32'hFFFFFFFF,
      64'hFFFFFFFFFFFFFFFF, 32'hFFFFFFFF, 8'd8},
    // R4: upper ones cleared
    '{1'b1,1'b0,2'd3,8'd15, 64'hFFFFFFFFFFFF7FFF, 64'h0, 32'h0, 32'h0,
      64'h7FFF, 32'h0, 8'd4},
    // R9: empty select changes nothing
    '{1'b1,1'b1,2'd1,8'd15, 64'h8000, 64'h1111111111111111, 32'h0, 32'h40,
      64'h1111111111118000, 32'h40, 8'd9},
    // R5: 2-byte zero extend
    '{1'b0,1'b0,2'd1,8'd3, 64'h123456789ABCDEFF, 64'h2222222222222222, 32'h0, 32'h0,
      64'h222222222222000F, 32'h0, 8'd5}
  };

  logic        clk;
  logic        rst_n;
  logic        op_sext, flag_en;
  logic [1:0]  size_code;
  logic [7:0]  pos;
  logic [63:0] src_val, dst_old, dst_new;
  logic [31:0] flag_sel, flags_in, flags_out;

  int n_chk;
  int n_fail;
  int wd_cnt;
  bit done;

  sxt_unit dut (
    .op_sext(op_sext), .flag_en(flag_en), .size_code(size_code), .pos(pos),
    .src_val(src_val), .dst_old(dst_old), .flag_sel(flag_sel), .flags_in(flags_in),
    .dst_new(dst_new), .flags_out(flags_out)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    op_sext = v.op; flag_en = v.fen; size_code = v.sz; pos = v.pos;
    src_val = v.src; dst_old = v.dst; flag_sel = v.fsel; flags_in = v.fin;
    #(HALF/2);
  endtask

  always @(posedge clk) begin
    wd_cnt <= wd_cnt + 1;
    if (wd_cnt > 5000 && !done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; wd_cnt = 0; done = 1'b0;
    rst_n = 1'b0;
    op_sext = 1'b0; flag_en = 1'b0; size_code = 2'd0; pos = 8'd0;
    src_val = '0; dst_old = '0; flag_sel = '0; flags_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R11: idle inputs give zero outputs in the same cycle
    @(negedge clk); #(HALF/2);
    chk("R11 idle dst", dst_new, 64'h0);
    chk("R11 idle flags", {32'h0, flags_out}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VT[i]);
      chk($sformatf("R%0d vec%0d dst", VT[i].rq, i), dst_new, VT[i].xd);
      chk($sformatf("R%0d vec%0d flags", VT[i].rq, i), {32'h0, flags_out}, {32'h0, VT[i].xf});
    end

    // R1 vs R3: same operands, op select flips the result at once (R11)
    apply('{1'b0,1'b1,2'd3,8'd7, 64'h80, 64'h0, 32'h00030041, 32'h0, 64'h0, 32'h0, 8'd0});
    chk("R1 zext of 0x80", dst_new, 64'h80);
    chk("R10 zext flags", {32'h0, flags_out}, 64'h0);
    op_sext = 1'b1; #1;
    chk("R11 sext same cycle", dst_new, 64'hFFFFFFFFFFFFFF80);
    chk("R8 sext flags same cycle", {32'h0, flags_out}, 64'h00030041);

    // R7: 8-byte result ignores destination content
    apply('{1'b1,1'b0,2'd3,8'd31, 64'h0000000012345678, 64'hDEADBEEFDEADBEEF, 32'h0, 32'h0, 64'h0, 32'h0, 8'd0});
    chk("R7 full write", dst_new, 64'h0000000012345678);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule